// File: doc/BRIEF.md
# Zero-Turnaround Burst Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. The word is 36 bits wide and split into four 9-bit byte lanes, and the depth is set by an address-width parameter. Address, command and write data are all captured on the rising clock edge. Reads and writes can follow each other in any order on consecutive clocks with no idle cycles between them. This works because a write takes its data two enabled clocks after its address, which is the same point at which a read returns its data.

A command is either loaded from the external pins or continued by an internal 2-bit burst counter, and the `advance` input chooses between the two. The `interleave` input sets the burst order. When it is high, the counter is XORed into the two low address bits. When it is low, the counter is added to them modulo 4. The `suspend` input freezes the entire pipeline. Read data and write data use separate ports.

Top module: `nowait_burst_sram`

## Requirements
- R1: After reset, `rdValid` is low and no command is in flight: the first two enabled clocks after reset produce no read data and commit no write.
- R2: On a clock edge where `suspend` is high, every input is ignored and all state holds, so `rdData` and `rdValid` keep their values.
- R3: On an enabled edge with `advance` low, a new command loads from the pins. `sel` low gives a deselect. `sel` high with `wrN` high gives a read. `sel` high with `wrN` low gives a write. The address on `addr` is the burst start.
- R4: On an enabled edge with `advance` high, the loaded command continues at the next burst address. The 2-bit beat count wraps after four beats, and address bits above bit 1 never change within a burst.
- R5: With `interleave` high at load, the two low bits of beat n are the two low bits of the start address XOR n.
- R6: With `interleave` low at load, the two low bits of beat n are the two low bits of the start address plus n, modulo 4.
- R7: A read issued on an enabled edge drives `rdValid` high and its word on `rdData` after the second enabled edge that follows.
- R8: A write's data and `laneEn` are sampled on the second enabled edge after its address edge. Lane i covers bits [9i+8:9i]. Lanes whose enable bit is low keep their stored contents.
- R9: A read returns the newest data for its address, including a write that is still in the pipeline, under any back-to-back mix of reads and writes.
- R10: A deselect leaves `rdValid` low in its output cycle. Beats continued with `advance` high after a deselect stay deselected and access no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of the control pipeline |
| suspend | input | 1 | High freezes the pipeline and ignores all inputs |
| advance | input | 1 | Low loads a new command, high steps the burst |
| sel | input | 1 | High selects the device when a command loads |
| wrN | input | 1 | Low selects write, high selects read, when a command loads |
| interleave | input | 1 | Burst order at load: 1 XOR order, 0 linear order |
| addr | input | AW | Start address of a loaded command |
| laneEn | input | 4 | Per-lane write enables, sampled with the write data |
| wrData | input | 36 | Write data, sampled two enabled clocks after the address |
| rdData | output | 36 | Read data |
| rdValid | output | 1 | High when rdData carries a read result |

## Verification
The bench checks a write immediately followed by a read of the same word. A design without the bypass would return the stale word in that case. It also runs bursts from every low start offset in both orders past four beats. Mixing up the XOR and add orders, or letting the counter carry into bit 2, would read the wrong word. Partial lane writes are read back so that a lane clobbered by a disabled enable shows up. Suspend cycles are placed inside bursts and between a write's address and its data, where a pipeline that leaks would shift the data one beat. Deselects continued by `advance` must stay silent, otherwise a phantom `rdValid` or memory write would appear.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic en;          // pipeline advances this edge
    logic rdFetch;     // stage-1 read: fetch array word
    logic wrCommit;    // stage-2 write: commit lanes
    logic outCapture;  // stage-2 read: load output register
  } strobe_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int BEAT_W = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          suspend,
  input  logic          advance,
  input  logic          sel,
  input  logic          wrN,
  input  logic          interleave,
  input  logic [AW-1:0] addr,
  output strobe_t       st,
  output logic [AW-1:0] rdAddr,
  output logic [AW-1:0] wrAddr,
  output op_e           s1Op,
  output logic          rdValid
);
  logic [AW-1:0]     s1Base;
  logic [BEAT_W-1:0] s1Beat;
  logic              s1Ilv;
  op_e               s2Op;
  logic [AW-1:0]     s2Addr;
  logic [BEAT_W-1:0] lowLin, lowIlv;
  logic [AW-1:0]     s1Addr;

  assign lowLin = s1Base[BEAT_W-1:0] + s1Beat;
  assign lowIlv = s1Base[BEAT_W-1:0] ^ s1Beat;
  assign s1Addr = {s1Base[AW-1:BEAT_W], (s1Ilv ? lowIlv : lowLin)};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Op    <= OP_IDLE;
      s1Base  <= '0;
      s1Beat  <= '0;
      s1Ilv   <= 1'b0;
      s2Op    <= OP_IDLE;
      s2Addr  <= '0;
      rdValid <= 1'b0;
    end else if (!suspend) begin
      if (!advance) begin
        s1Op   <= !sel ? OP_IDLE : (wrN ? OP_READ : OP_WRITE);
        s1Base <= addr;
        s1Beat <= '0;
        s1Ilv  <= interleave;
      end else begin
        s1Beat <= s1Beat + 1'b1;
      end
      s2Op    <= s1Op;
      s2Addr  <= s1Addr;
      rdValid <= (s2Op == OP_READ);
    end
  end

  always_comb begin
    st.en         = !suspend;
    st.rdFetch    = (s1Op == OP_READ);
    st.wrCommit   = (s2Op == OP_WRITE);
    st.outCapture = (s2Op == OP_READ);
  end

  assign rdAddr = s1Addr;
  assign wrAddr = s2Addr;
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int LANES = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 st,
  input  logic [AW-1:0]           rdAddr,
  input  logic [AW-1:0]           wrAddr,
  input  logic [LANES-1:0]        laneEn,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] rdData
);
  localparam int DW = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] arrWord, merged, fetchQ;
  logic          sameAddr;

  assign arrWord  = mem[rdAddr];
  assign sameAddr = st.wrCommit && (wrAddr == rdAddr);

  // bypass: a write committing this edge overrides the array word lane by lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign merged[g*LANE_W +: LANE_W] = (sameAddr && laneEn[g])
                                        ? wrData[g*LANE_W +: LANE_W]
                                        : arrWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (st.en && st.wrCommit) begin
      for (int i = 0; i < LANES; i++) begin
        if (laneEn[i]) mem[wrAddr][i*LANE_W +: LANE_W] <= wrData[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st.en && st.rdFetch) fetchQ <= merged;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (st.en && st.outCapture) rdData <= fetchQ;
  end
endmodule

// File: rtl/nowait_burst_sram.sv
module nowait_burst_sram
  import sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int LANES = 4,
  parameter int LANE_W = 9,
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             suspend,
  input  logic             advance,
  input  logic             sel,
  input  logic             wrN,
  input  logic             interleave,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] laneEn,
  input  logic [DW-1:0]    wrData,
  output logic [DW-1:0]    rdData,
  output logic             rdValid
);
  strobe_t       st;
  logic [AW-1:0] rdAddr, wrAddr;
  op_e           s1Op;

  sram_ctrl #(.AW(AW), .BEAT_W(2)) uCtrl (
    .clk(clk), .rstN(rstN), .suspend(suspend), .advance(advance),
    .sel(sel), .wrN(wrN), .interleave(interleave), .addr(addr),
    .st(st), .rdAddr(rdAddr), .wrAddr(wrAddr), .s1Op(s1Op), .rdValid(rdValid)
  );

  sram_datapath #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk(clk), .rstN(rstN), .st(st), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .laneEn(laneEn), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/sram_checker.sv
module sram_checker
  import sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rstN,
  input logic          suspend,
  input logic          advance,
  input logic          sel,
  input logic          wrN,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdData,
  input logic          rdValid,
  input strobe_t       st,
  input op_e           s1Op,
  input logic [AW-1:0] rdAddr
);
  AST_FREEZE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> ($stable(rdData) && $stable(rdValid)));  // R2

  AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!suspend && !advance && sel && !wrN) |=> (s1Op == OP_WRITE));  // R3

  AST_LOAD_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!suspend && !advance && sel && wrN) |=> (s1Op == OP_READ));  // R3

  AST_BURST_START: assert property (@(posedge clk) disable iff (!rstN)
    (!suspend && !advance) |=> (rdAddr == $past(addr)));  // R4

  AST_IDLE_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (!suspend && advance && s1Op == OP_IDLE) |=> (s1Op == OP_IDLE));  // R10

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!suspend && st.outCapture) |=> rdValid);  // R7

  AST_NO_VALID_OTHERWISE: assert property (@(posedge clk) disable iff (!rstN)
    (!suspend && !st.outCapture) |=> !rdValid);  // R10
endmodule

bind nowait_burst_sram sram_checker #(.AW(AW), .DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .suspend(suspend), .advance(advance), .sel(sel),
  .wrN(wrN), .addr(addr), .rdData(rdData), .rdValid(rdValid), .st(st),
  .s1Op(s1Op), .rdAddr(rdAddr)
);

// File: tb/nowait_burst_sram_test.sv
`timescale 1ns/1ps
module nowait_burst_sram_test;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN, suspend, advance, sel, wrN, interleave;
  logic [AW-1:0] addr;
  logic [3:0] laneEn;
  logic [35:0] wrData, rdData;
  logic rdValid;

  always #2.5 clk = ~clk;

  nowait_burst_sram #(.AW(AW)) uut (
    .clk(clk), .rstN(rstN), .suspend(suspend), .advance(advance), .sel(sel),
    .wrN(wrN), .interleave(interleave), .addr(addr), .laneEn(laneEn),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  int vectors = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  logic [35:0] mm [DEPTH];
  int opKind[$];
  int opAddr[$];
  int mCmd, mBase, mBeat, mIlv;
  logic expValid;
  logic [35:0] expData;

  task automatic modelReset();
    opKind = {0, 0};
    opAddr = {0, 0};
    mCmd = 0; mBase = 0; mBeat = 0; mIlv = 0;
    expValid = 1'b0;
  endtask

  task automatic modelStep();
    int low, a, k, a0;
    if (suspend) return;
    if (!advance) begin
      mCmd = !sel ? 0 : (wrN ? 1 : 2);
      mBase = int'(addr); mBeat = 0; mIlv = int'(interleave);
    end else mBeat = (mBeat + 1) % 4;
    low = mIlv ? ((mBase % 4) ^ mBeat) : (((mBase % 4) + mBeat) % 4);
    a = (mBase / 4) * 4 + low;
    opKind.push_back(mCmd);
    opAddr.push_back(a);
    k = opKind.pop_front();
    a0 = opAddr.pop_front();
    if (k == 2) begin
      for (int i = 0; i < 4; i++)
        if (laneEn[i]) mm[a0][i*9 +: 9] = wrData[i*9 +: 9];
      expValid = 1'b0;
    end else if (k == 1) begin
      expValid = 1'b1;
      expData = mm[a0];
    end else expValid = 1'b0;
  endtask

  task automatic compare();
    vectors++;
    if (rdValid !== expValid) begin
      errors++;
      $display("FAIL %s rdValid actual=%b expected=%b t=%0t", tag, rdValid, expValid, $time);
    end
    if (expValid) begin
      vectors++;
      if (rdData !== expData) begin
        errors++;
        $display("FAIL %s rdData actual=%h expected=%h t=%0t", tag, rdData, expData, $time);
      end
    end
  endtask

  task automatic issue(input bit s, input bit w, input bit adv, input int a,
                       input bit ilv, input bit susp, input logic [3:0] le,
                       input logic [35:0] d);
    @(negedge clk);
    compare();
    sel = s; wrN = w; advance = adv; addr = AW'(a); interleave = ilv;
    suspend = susp; laneEn = le; wrData = d;
    modelStep();
  endtask

  function automatic logic [35:0] rnd36();
    return {$urandom, $urandom} & 36'hF_FFFF_FFFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; suspend = 0; advance = 0; sel = 0; wrN = 1; interleave = 0;
    addr = '0; laneEn = 4'hF; wrData = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    modelReset();
    // R1: reset state, two idle cycles
    tag = "R1";
    vectors++;
    if (rdValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rdValid actual=%b expected=0", rdValid);
    end
    issue(0, 1, 0, 0, 0, 0, 4'hF, 36'h0);
    issue(0, 1, 1, 0, 0, 0, 4'hF, 36'h0);

    // R8/R3: fill every word with full-lane writes
    tag = "R8";
    for (int a = 0; a < DEPTH; a++) issue(1, 0, 0, a, 0, 0, 4'hF, rnd36());
    issue(0, 1, 0, 0, 0, 0, 4'hF, rnd36());
    issue(0, 1, 0, 0, 0, 0, 4'hF, rnd36());

    // R3: plain reads of loaded commands
    tag = "R3";
    for (int a = 0; a < 6; a++) issue(1, 1, 0, a * 37 % DEPTH, 0, 0, 4'h0, 36'h0);

    // R5 / R6 / R4: bursts from every start offset, six beats to cross the wrap
    for (int m = 0; m < 2; m++) begin
      tag = (m == 1) ? "R5" : "R6";
      for (int off = 0; off < 4; off++) begin
        issue(1, 1, 0, 64 + off, m, 0, 4'h0, 36'h0);
        for (int b = 0; b < 5; b++) begin
          if (b == 3) tag = "R4";
          issue(0, 0, 1, 0, 0, 0, 4'h0, 36'h0);
        end
        tag = (m == 1) ? "R5" : "R6";
      end
    end

    // R8: partial-lane burst write, then burst read
    tag = "R8";
    issue(1, 0, 0, 20, 0, 0, 4'h0, 36'h0);
    issue(0, 1, 1, 0, 0, 0, 4'h0, 36'h0);
    issue(0, 1, 1, 0, 0, 0, 4'b0101, rnd36());
    issue(0, 1, 1, 0, 0, 0, 4'b1010, rnd36());
    issue(0, 1, 1, 0, 0, 0, 4'b0001, rnd36());
    issue(1, 1, 0, 20, 0, 0, 4'b1000, rnd36());
    for (int b = 0; b < 5; b++) issue(0, 1, 1, 0, 0, 0, 4'h0, 36'h0);

    // R9: write then immediate read of the same word, partial lanes
    tag = "R9";
    for (int a = 0; a < 8; a++) begin
      issue(1, 0, 0, 100 + a, 0, 0, 4'($urandom), rnd36());
      issue(1, 1, 0, 100 + a, 0, 0, 4'($urandom), rnd36());
    end
    issue(0, 1, 0, 0, 0, 0, 4'hF, rnd36());
    issue(0, 1, 0, 0, 0, 0, 4'hF, rnd36());

    // R10: deselect continued by advance stays silent
    tag = "R10";
    issue(0, 0, 0, 30, 0, 0, 4'hF, rnd36());
    for (int b = 0; b < 5; b++) issue(1, 0, 1, 30, 0, 0, 4'hF, rnd36());
    issue(1, 1, 0, 30, 0, 0, 4'h0, 36'h0);
    issue(0, 1, 0, 0, 0, 0, 4'h0, 36'h0);

    // R2 / R7: suspend inside a burst and inside a write's data window
    tag = "R2";
    issue(1, 0, 0, 200, 1, 0, 4'hF, 36'h0);
    issue(0, 0, 0, 0, 0, 1, 4'hF, rnd36());
    issue(0, 0, 0, 0, 0, 1, 4'hF, rnd36());
    issue(0, 1, 1, 0, 0, 0, 4'hF, rnd36());
    issue(1, 1, 0, 200, 0, 1, 4'hF, rnd36());
    issue(1, 1, 0, 200, 0, 0, 4'hF, rnd36());
    tag = "R7";
    issue(0, 1, 1, 0, 0, 0, 4'h0, 36'h0);
    issue(0, 1, 1, 0, 0, 1, 4'h0, 36'h0);
    issue(0, 1, 1, 0, 0, 0, 4'h0, 36'h0);
    issue(0, 1, 0, 0, 0, 0, 4'h0, 36'h0);
    issue(0, 1, 0, 0, 0, 0, 4'h0, 36'h0);

    // R9: random back-to-back mix
    tag = "R9";
    for (int n = 0; n < 4000; n++)
      issue(($urandom % 8) != 0, $urandom % 2, ($urandom % 5) < 2, $urandom % DEPTH,
            $urandom % 2, ($urandom % 10) == 0, 4'($urandom), rnd36());
    issue(0, 1, 0, 0, 0, 0, 4'hF, rnd36());
    issue(0, 1, 0, 0, 0, 0, 4'hF, rnd36());
    issue(0, 1, 0, 0, 0, 0, 4'hF, rnd36());

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule